// File: doc/BRIEF.md
# Event Counting Performance Monitor

The block keeps two 32-bit event counters. A control register picks, for each counter, which single-cycle event pulse advances it: every clock cycle, an instruction cache miss, a data cache miss, a dispatch to one chosen execution unit, or a mispredicted branch. It also holds a freeze bit that stops both counters, and the enables for the interrupt sources.

A monitor interrupt request is raised for either of two reasons. The first is a counter turning negative, which means its most significant bit is set. The second is a flip of a chosen bit of the 64-bit time base. A counter-negative trigger is treated as a threshold event. On that cycle the block captures the current instruction address and data address into two sample registers. Raising the request clears the global interrupt enable, so one trigger gives one request. The request stays up until it is acknowledged, and it presents the vector offset 0x00F00.

A small fixed-priority arbiter ranks the monitor request between an external interrupt above it and a decrementer interrupt below it. Software reaches the counters, the control register and the sample registers through a single-cycle register port.

Top module: `perf_mon`

## Requirements
- R1: After reset, all readable registers are zero, `irq_o` is low, `vec_o` is zero and no grant bit is set.
- R2: A counter adds one on each clock edge where its selected event is present and the block is not frozen. Event codes: 0 none, 1 every cycle, 2 instruction cache miss, 3 data cache miss, 4 dispatch to the unit named in control bits [15:14], 5 mispredicted branch. Counter 0 uses control bits [9:6] and counter 1 uses bits [13:10].
- R3: While control bit 0 (freeze) is 1, neither counter changes except through a register write.
- R4: A register write to a counter in the same cycle as a counted event loads the written value, and the increment is lost.
- R5: When control bit 1 (interrupt enable) and bit 2 (negative enable) are set and either counter has its MSB set, `irq_o` rises on the next edge and bit 1 reads back as 0. With bit 1 clear, no new request is raised.
- R6: When control bits 1 and 3 (time-base enable) are set, a change of the time-base bit chosen by control bits [5:4] (code 0..3 selects bit 0, 8, 12 or 16) raises `irq_o` on the edge where the change is first seen. Changes of the unselected bits have no effect.
- R7: The sample registers take `iaddr_i` and `daddr_i` only on the edge where a counter-negative trigger raises the request. They keep their values after a time-base trigger and while the addresses change.
- R8: `irq_o` stays high until an edge with `irq_ack_i` high. `vec_o` is 0x00F00 while `irq_o` is high and zero otherwise.
- R9: `grant_o` has at most one bit set, chosen by fixed priority: bit 0 external (highest), bit 1 monitor request, bit 2 decrementer.
- R10: Register addresses: 0 control (16 bits, upper read bits zero), 1 counter 0, 2 counter 1, 3 sampled instruction address, 4 sampled data address. Other addresses read zero. Writes take effect on the edge and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ic_miss_i | input | 1 | Instruction cache miss pulse |
| dc_miss_i | input | 1 | Data cache miss pulse |
| disp_i | input | 4 | Dispatch pulse per execution unit |
| br_miss_i | input | 1 | Mispredicted branch pulse |
| tb_i | input | 64 | Time base value |
| iaddr_i | input | 32 | Current instruction address |
| daddr_i | input | 32 | Current data address |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| ext_irq_i | input | 1 | External interrupt request |
| dec_irq_i | input | 1 | Decrementer interrupt request |
| irq_ack_i | input | 1 | Acknowledge of the monitor request |
| irq_o | output | 1 | Monitor interrupt request |
| vec_o | output | 20 | Vector offset while requesting |
| grant_o | output | 3 | One-hot grant: ext, monitor, decrementer |

## Verification
A wrong count shows up through the register port at the first read after the faulty edge. The bench reads counters right after writes and pulses, so an increment that is lost, doubled or ignores freeze is caught within a cycle. A wrong trigger or enable state shows on `irq_o` one edge after the counter's MSB sets or the tapped time-base bit changes, and the bench samples every cycle around that edge to catch early or late requests. A bad capture shows as a sample register value taken from the neighbouring cycle, because the addresses change on each side of the trigger edge.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;
  localparam int NUM_CNT   = 2;
  localparam int NUM_UNITS = 4;
  localparam int UNIT_W    = $clog2(NUM_UNITS);
  localparam int CTRL_W    = 16;
  localparam int NUM_TAPS  = 4;
  localparam int TAP_SEL_W = $clog2(NUM_TAPS);
  localparam int NUM_REQ   = 3;

  // control register fields
  localparam int C_FRZ    = 0;
  localparam int C_IE     = 1;
  localparam int C_NEG_EN = 2;
  localparam int C_TB_EN  = 3;
  localparam int C_TB_SEL = 4;
  localparam int C_SEL0   = 6;
  localparam int SEL_W    = 4;
  localparam int C_UNIT   = 14;

  typedef enum logic [SEL_W-1:0] {
    EV_NONE = 4'd0, EV_CLK = 4'd1, EV_ICM = 4'd2,
    EV_DCM  = 4'd3, EV_DSP = 4'd4, EV_BRM = 4'd5
  } evt_e;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0, A_CNT0 = 3'd1, A_CNT1 = 3'd2, A_SIA = 3'd3, A_SDA = 3'd4
  } reg_addr_e;

  function automatic int tap_pos(input int k);
    case (k)
      0:       return 0;
      1:       return 8;
      2:       return 12;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/perf_mon_evt_sel.sv
module perf_mon_evt_sel
  import perf_mon_pkg::*;
(
  input  evt_e                  sel_i,
  input  logic [UNIT_W-1:0]     unit_i,
  input  logic                  ic_miss_i,
  input  logic                  dc_miss_i,
  input  logic [NUM_UNITS-1:0]  disp_i,
  input  logic                  br_miss_i,
  output logic                  hit_o
);
  always_comb begin
    unique case (sel_i)
      EV_CLK:  hit_o = 1'b1;
      EV_ICM:  hit_o = ic_miss_i;
      EV_DCM:  hit_o = dc_miss_i;
      EV_DSP:  hit_o = disp_i[unit_i];
      EV_BRM:  hit_o = br_miss_i;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/perf_mon_cnt.sv
module perf_mon_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (wr_i)  cnt_o <= wdata_i;   // software write beats increment
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/perf_mon_arb.sv
module perf_mon_arb #(
  parameter int N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  // lowest index wins
  assign grant_o = req_i & (~req_i + 1'b1);
endmodule

// File: rtl/perf_mon.sv
module perf_mon
  import perf_mon_pkg::*;
#(
  parameter int          CNT_W   = 32,
  parameter int          ADDR_W  = 32,
  parameter int          TB_W    = 64,
  parameter int          VEC_W   = 20,
  parameter logic [19:0] VEC_OFS = 20'h00F00
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ic_miss_i,
  input  logic                 dc_miss_i,
  input  logic [NUM_UNITS-1:0] disp_i,
  input  logic                 br_miss_i,
  input  logic [TB_W-1:0]      tb_i,
  input  logic [ADDR_W-1:0]    iaddr_i,
  input  logic [ADDR_W-1:0]    daddr_i,
  input  logic                 reg_we_i,
  input  logic [2:0]           reg_addr_i,
  input  logic [CNT_W-1:0]     reg_wdata_i,
  output logic [CNT_W-1:0]     reg_rdata_o,
  input  logic                 ext_irq_i,
  input  logic                 dec_irq_i,
  input  logic                 irq_ack_i,
  output logic                 irq_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic [NUM_REQ-1:0]   grant_o
);
  logic [CTRL_W-1:0]      ctrl_q;
  logic [CNT_W-1:0]       cnt_q [NUM_CNT];
  logic [NUM_CNT-1:0]     cnt_msb;
  logic [ADDR_W-1:0]      sia_q, sda_q;
  logic                   req_q;
  logic [NUM_TAPS-1:0]    tap, tap_q;
  logic                   tap_vld_q;
  logic [TAP_SEL_W-1:0]   tap_sel;
  logic                   tb_flip, neg_any, trig, samp;
  logic                   wr_ctrl, wr_sia, wr_sda;

  assign wr_ctrl = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_sia  = reg_we_i && (reg_addr_i == A_SIA);
  assign wr_sda  = reg_we_i && (reg_addr_i == A_SDA);

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    logic hit;
    perf_mon_evt_sel u_sel (
      .sel_i     (evt_e'(ctrl_q[C_SEL0 + c*SEL_W +: SEL_W])),
      .unit_i    (ctrl_q[C_UNIT +: UNIT_W]),
      .ic_miss_i (ic_miss_i),
      .dc_miss_i (dc_miss_i),
      .disp_i    (disp_i),
      .br_miss_i (br_miss_i),
      .hit_o     (hit)
    );
    perf_mon_cnt #(.W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (hit && !ctrl_q[C_FRZ]),
      .wr_i    (reg_we_i && (reg_addr_i == 3'(c + 1))),
      .wdata_i (reg_wdata_i),
      .cnt_o   (cnt_q[c])
    );
    assign cnt_msb[c] = cnt_q[c][CNT_W-1];
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    assign tap[k] = tb_i[tap_pos(k)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tap_q     <= '0;
      tap_vld_q <= 1'b0;
    end else begin
      tap_q     <= tap;
      tap_vld_q <= 1'b1;
    end
  end

  assign tap_sel = ctrl_q[C_TB_SEL +: TAP_SEL_W];
  assign tb_flip = tap_vld_q && (tap[tap_sel] != tap_q[tap_sel]);
  assign neg_any = |cnt_msb;
  assign samp    = ctrl_q[C_IE] && ctrl_q[C_NEG_EN] && neg_any;
  assign trig    = samp || (ctrl_q[C_IE] && ctrl_q[C_TB_EN] && tb_flip);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      req_q  <= 1'b0;
      sia_q  <= '0;
      sda_q  <= '0;
    end else begin
      if (wr_ctrl)   ctrl_q       <= reg_wdata_i[CTRL_W-1:0];
      else if (trig) ctrl_q[C_IE] <= 1'b0;
      if (trig)           req_q <= 1'b1;
      else if (irq_ack_i) req_q <= 1'b0;
      if (wr_sia)    sia_q <= reg_wdata_i[ADDR_W-1:0];
      else if (samp) sia_q <= iaddr_i;
      if (wr_sda)    sda_q <= reg_wdata_i[ADDR_W-1:0];
      else if (samp) sda_q <= daddr_i;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CTRL:  reg_rdata_o = CNT_W'(ctrl_q);
      A_CNT0:  reg_rdata_o = cnt_q[0];
      A_CNT1:  reg_rdata_o = cnt_q[1];
      A_SIA:   reg_rdata_o = CNT_W'(sia_q);
      A_SDA:   reg_rdata_o = CNT_W'(sda_q);
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = req_q;
  assign vec_o = req_q ? VEC_OFS[VEC_W-1:0] : '0;

  perf_mon_arb #(.N(NUM_REQ)) u_arb (
    .req_i   ({dec_irq_i, req_q, ext_irq_i}),
    .grant_o (grant_o)
  );
endmodule

// File: rtl/perf_mon_chk.sv
module perf_mon_chk
  import perf_mon_pkg::*;
#(
  parameter int          CNT_W   = 32,
  parameter int          ADDR_W  = 32,
  parameter int          VEC_W   = 20,
  parameter logic [19:0] VEC_OFS = 20'h00F00
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ext_irq_i,
  input logic               irq_ack_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic [2:0]         grant_o,
  input logic               reg_we_i,
  input logic [2:0]         reg_addr_i,
  input logic               frz,
  input logic               ie,
  input logic               trig,
  input logic               samp,
  input logic [CNT_W-1:0]   cnt0,
  input logic [CNT_W-1:0]   cnt1,
  input logic [ADDR_W-1:0]  sia
);
  p_grant_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  p_ext_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_irq_i |-> grant_o == 3'b001);

  p_pm_over_dec_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ext_irq_i) |-> grant_o == 3'b010);

  p_vec_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> vec_o == VEC_OFS[VEC_W-1:0]);

  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o);

  p_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz && !reg_we_i) |=> ($stable(cnt0) && $stable(cnt1)));

  p_ie_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig && !(reg_we_i && reg_addr_i == A_CTRL)) |=> (!ie && irq_o));

  p_rise_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(trig));

  p_sample_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!samp && !(reg_we_i && reg_addr_i == A_SIA)) |=> $stable(sia));
endmodule

bind perf_mon perf_mon_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W), .VEC_OFS(VEC_OFS)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ext_irq_i  (ext_irq_i),
  .irq_ack_i  (irq_ack_i),
  .irq_o      (irq_o),
  .vec_o      (vec_o),
  .grant_o    (grant_o),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .frz        (ctrl_q[0]),
  .ie         (ctrl_q[1]),
  .trig       (trig),
  .samp       (samp),
  .cnt0       (cnt_q[0]),
  .cnt1       (cnt_q[1]),
  .sia        (sia_q)
);

// File: tb/perf_mon_tb_top.sv
module perf_mon_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ic_miss_i = 1'b0, dc_miss_i = 1'b0, br_miss_i = 1'b0;
  logic [3:0]  disp_i = '0;
  logic [63:0] tb_i = '0;
  logic [31:0] iaddr_i = '0, daddr_i = '0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        ext_irq_i = 1'b0, dec_irq_i = 1'b0, irq_ack_i = 1'b0;
  logic        irq_o;
  logic [19:0] vec_o;
  logic [2:0]  grant_o;

  int total = 0;
  int bad = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  perf_mon dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ic_miss_i(ic_miss_i), .dc_miss_i(dc_miss_i),
    .disp_i(disp_i), .br_miss_i(br_miss_i), .tb_i(tb_i), .iaddr_i(iaddr_i),
    .daddr_i(daddr_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .ext_irq_i(ext_irq_i),
    .dec_irq_i(dec_irq_i), .irq_ack_i(irq_ack_i), .irq_o(irq_o), .vec_o(vec_o),
    .grant_o(grant_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tasks enter and leave at a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic pulse(input int kind, input logic [3:0] unit_mask);
    case (kind)
      2: ic_miss_i = 1'b1;
      3: dc_miss_i = 1'b1;
      4: disp_i = unit_mask;
      default: br_miss_i = 1'b1;
    endcase
    @(negedge clk_i);
    ic_miss_i = 1'b0; dc_miss_i = 1'b0; br_miss_i = 1'b0; disp_i = '0;
  endtask

  task automatic ack();
    irq_ack_i = 1'b1;
    @(negedge clk_i);
    irq_ack_i = 1'b0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), rv);
      check($sformatf("R1 reg %0d after reset", a), rv, 32'h0);
    end
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    check("R1 vec after reset", {12'b0, vec_o}, 32'h0);
    check("R1 grant after reset", {29'b0, grant_o}, 32'h0);
  endtask

  task automatic t_count();
    wr(0, (2 << 6) | (3 << 10));             // cnt0=icache miss, cnt1=dcache miss
    repeat (3) pulse(2, '0);
    pulse(3, '0);
    pulse(5, '0);
    rd(1, rv); check("R2 icache miss count", rv, 32'd3);
    rd(2, rv); check("R2 dcache miss count", rv, 32'd1);
    wr(0, (4 << 6) | (5 << 10) | (2 << 14)); // dispatch unit 2, branch mispredict
    wr(1, 0);
    wr(2, 0);
    pulse(4, 4'b0100);
    pulse(4, 4'b0001);
    pulse(4, 4'b0100);
    pulse(5, '0);
    pulse(5, '0);
    rd(1, rv); check("R2 dispatch unit 2 count", rv, 32'd2);
    rd(2, rv); check("R2 mispredict count", rv, 32'd2);
    wr(0, (1 << 6) | 1);                     // every cycle, frozen
    wr(1, 0);
    wr(0, (1 << 6));                         // unfreeze
    repeat (9) @(negedge clk_i);
    wr(0, (1 << 6) | 1);                     // freeze counts this edge too
    rd(1, rv); check("R2 clock count over 10 edges", rv, 32'd10);
  endtask

  task automatic t_freeze();
    wr(0, 1 | (2 << 6) | (3 << 10));
    pulse(2, '0); pulse(3, '0); pulse(2, '0);
    repeat (4) @(negedge clk_i);
    rd(1, rv); check("R3 cnt0 frozen", rv, 32'd10);
    rd(2, rv); check("R3 cnt1 frozen", rv, 32'd2);
  endtask

  task automatic t_wr_prio();
    wr(0, (1 << 6));
    wr(1, 32'd100);
    rd(1, rv); check("R4 write beats increment", rv, 32'd100);
    @(negedge clk_i);
    rd(1, rv); check("R4 counting resumes", rv, 32'd101);
    wr(0, 1);
  endtask

  task automatic t_neg();
    iaddr_i = 32'h1000_0040; daddr_i = 32'h2000_0080;
    wr(0, 32'h47);                           // frz, ie, neg_en, cnt0 every cycle
    wr(1, 32'h7FFF_FFFE);
    wr(2, 0);
    wr(0, 32'h46);                           // unfreeze
    check("R5 no request before negative", {31'b0, irq_o}, 32'h0);
    @(negedge clk_i);
    check("R5 no request at 7fffffff", {31'b0, irq_o}, 32'h0);
    @(negedge clk_i);
    rd(1, rv); check("R5 counter now negative", rv, 32'h8000_0000);
    check("R5 request not yet raised", {31'b0, irq_o}, 32'h0);
    iaddr_i = 32'h1000_0044; daddr_i = 32'h2000_0088;
    @(negedge clk_i);
    check("R5 request raised", {31'b0, irq_o}, 32'h1);
    check("R8 vector while requesting", {12'b0, vec_o}, 32'h0000_0F00);
    iaddr_i = 32'hDEAD_0000; daddr_i = 32'hBEEF_0000;
    rd(3, rv); check("R7 sampled instr addr", rv, 32'h1000_0044);
    rd(4, rv); check("R7 sampled data addr", rv, 32'h2000_0088);
    rd(0, rv); check("R5 enable auto-cleared", rv, 32'h44);
    repeat (3) @(negedge clk_i);
    check("R8 request held without ack", {31'b0, irq_o}, 32'h1);
    rd(3, rv); check("R7 sample held", rv, 32'h1000_0044);
    ext_irq_i = 1'b1; dec_irq_i = 1'b1; #1;
    check("R9 external wins", {29'b0, grant_o}, 32'h1);
    ext_irq_i = 1'b0; #1;
    check("R9 monitor over decrementer", {29'b0, grant_o}, 32'h2);
    ack();
    check("R8 request cleared by ack", {31'b0, irq_o}, 32'h0);
    check("R8 vector zero when idle", {12'b0, vec_o}, 32'h0);
    check("R9 decrementer alone", {29'b0, grant_o}, 32'h4);
    repeat (2) @(negedge clk_i);
    check("R5 no repeat with enable clear", {31'b0, irq_o}, 32'h0);
    dec_irq_i = 1'b0; #1;
    check("R9 no grant when idle", {29'b0, grant_o}, 32'h0);
    wr(0, 1);
  endtask

  task automatic t_tb();
    wr(1, 0);
    wr(0, 32'h2B);                           // frz, ie, tb_en, tap sel 2 (bit 12)
    tb_i[8] = ~tb_i[8];
    repeat (2) @(negedge clk_i);
    check("R6 unselected bit ignored", {31'b0, irq_o}, 32'h0);
    tb_i[12] = ~tb_i[12];
    @(negedge clk_i);
    check("R6 selected bit 12 flip", {31'b0, irq_o}, 32'h1);
    rd(3, rv); check("R7 no sample on time-base trigger", rv, 32'h1000_0044);
    rd(0, rv); check("R6 enable auto-cleared", rv, 32'h29);
    ack();
    wr(0, 32'h0B);                           // tap sel 0 (bit 0)
    tb_i[0] = 1'b1;
    @(negedge clk_i);
    check("R6 selected bit 0 flip", {31'b0, irq_o}, 32'h1);
    ack();
    tb_i[0] = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R5 flip ignored with enable clear", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_regs();
    wr(3, 32'hCAFE_0001);
    rd(3, rv); check("R10 sia write", rv, 32'hCAFE_0001);
    wr(4, 32'h0BAD_F00D);
    rd(4, rv); check("R10 sda write", rv, 32'h0BAD_F00D);
    wr(0, 32'hFFFF_FFF1);
    rd(0, rv); check("R10 control width 16", rv, 32'h0000_FFF1);
    wr(5, 32'h1234_5678);
    rd(5, rv); check("R10 unused address reads zero", rv, 32'h0);
    rd(1, rv); check("R10 write to unused address ignored", rv, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_count();
    t_freeze();
    t_wr_prio();
    t_neg();
    t_tb();
    t_regs();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule